// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter

A small counter stage that holds a value of `W` bits and steps it by one on a rising clock edge when both of its count enables are high. A parallel preset can be loaded on any edge, and an active-low clear returns the value to zero. Every state bit is written by the same edge, so the output never shows intermediate codes while it changes.

Two parameters select the variant. `DECADE` picks whether the value counts through all `2**W` codes or through 0 to 9 (BCD). `ASYNC_CLR` picks whether the clear acts at once, with no clock, or on the next edge like the other controls. The carry output is high when the count sits at its terminal value (all ones, or 9 in decade mode) and the trailing enable `en_t` is high. The other enable, `en_p`, has no part in the carry. Feeding each stage's carry into the next stage's `en_t` therefore builds a wider synchronous counter with no extra gates.

Top module: `sync_preset_counter`

## Requirements
- R1: The stored count changes only at a rising clock edge (except for the asynchronous clear of R5). Changing `load_n`, `en_p` or `en_t` between edges leaves `count` unchanged until the next edge.
- R2: With `clr_n` and `load_n` high, the count advances by one at an edge only when `en_p` and `en_t` are both 1. If either is 0, the count holds.
- R3: With `clr_n` high and `load_n` low, the next edge copies `preset` into `count`, whatever the enable levels.
- R4: With `ASYNC_CLR`=0, a low `clr_n` makes `count` zero at the next edge, and this wins over a low `load_n` and over the enables.
- R5: With `ASYNC_CLR`=1, a low `clr_n` makes `count` zero at once, without waiting for a clock edge, and the count stays zero while `clr_n` is low.
- R6: `carry_out` is 1 exactly when `en_t` is 1 and `count` equals the terminal value: `2**W-1` with `DECADE`=0, or 9 with `DECADE`=1. `en_p` has no effect on it.
- R7: With `DECADE`=0, an enabled count at `2**W-1` (15 for W=4) wraps to 0.
- R8: With `DECADE`=1, an enabled count at 9 wraps to 0.
- R9: With `DECADE`=1, a loaded value from 10 to 15 steps up by one per enabled edge (for example 13, 14, 15, 0), and `carry_out` stays 0 on those codes.
- R10: Two stages in which the low stage's `carry_out` drives the high stage's `en_t`, with shared clock and `en_p`, form one synchronous counter of 2W bits. For W=4 it steps 0xEE, 0xEF, 0xF0, 0xF1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear, synchronous or asynchronous per `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load of `preset` |
| preset | input | W | Value loaded when `load_n` is low |
| en_p | input | 1 | Count enable; does not affect the carry |
| en_t | input | 1 | Count enable; also gates `carry_out` |
| count | output | W | Present count value |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
The hardest state to reach from the ports is a decade stage holding a code above 9. Counting cannot get there, so the bench loads 13 and then steps through 14 and 15 to 0, checking that the carry stays low the whole way. The asynchronous clear is another hard case: it must be seen to act between edges. The bench lowers `clr_n` shortly after an edge and samples the decade (asynchronous) instance before the next edge. At that point the synchronous instance must still hold its old value.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } spc_action_e;

  // Terminal value for a stage of the given width and modulus choice
  function automatic int unsigned term_value(int unsigned width, bit decade);
    if (decade) return 9;
    return (1 << width) - 1;
  endfunction

endpackage

// File: rtl/spc_action_sel.sv
module spc_action_sel
  import spc_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic        clr_n,
  input  logic        load_n,
  input  logic        en_p,
  input  logic        en_t,
  output spc_action_e action
);

  logic clr_req;

  generate
    if (SYNC_CLR) begin : g_sync
      assign clr_req = ~clr_n;
    end else begin : g_async
      // clear handled by the register's asynchronous path
      assign clr_req = 1'b0;
    end
  endgenerate

  // priority: clear, load, count, hold
  always_comb begin
    if (clr_req)            action = ACT_CLEAR;
    else if (!load_n)       action = ACT_LOAD;
    else if (en_p && en_t)  action = ACT_COUNT;
    else                    action = ACT_HOLD;
  end

endmodule

// File: rtl/spc_next_value.sv
module spc_next_value
  import spc_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b0
) (
  input  spc_action_e  action,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] preset,
  output logic [W-1:0] nxt,
  output logic         upd_en
);

  localparam logic [W-1:0] TERM = W'(term_value(W, DECADE));

  logic [W-1:0] succ;

  // At the terminal value the stage wraps. Codes above the terminal in
  // decade mode simply increment and wrap through the width's overflow.
  always_comb begin
    if (cur == TERM) succ = '0;
    else             succ = cur + W'(1);
  end

  always_comb begin
    unique case (action)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = preset;
      ACT_COUNT: nxt = succ;
      default:   nxt = cur;
    endcase
    upd_en = (action != ACT_HOLD);
  end

endmodule

// File: rtl/spc_term_detect.sv
module spc_term_detect
  import spc_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [W-1:0] cur,
  input  logic         en_t,
  output logic         carry
);

  localparam logic [W-1:0] TERM = W'(term_value(W, DECADE));

  always_comb carry = en_t && (cur == TERM);

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import spc_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] count,
  output logic         carry_out
);

  spc_action_e  action;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         upd_en;

  spc_action_sel #(
    .SYNC_CLR(!ASYNC_CLR)
  ) u_sel (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .action(action)
  );

  spc_next_value #(
    .W     (W),
    .DECADE(DECADE)
  ) u_nxt (
    .action(action),
    .cur   (cnt_q),
    .preset(preset),
    .nxt   (cnt_d),
    .upd_en(upd_en)
  );

  spc_term_detect #(
    .W     (W),
    .DECADE(DECADE)
  ) u_term (
    .cur  (cnt_q),
    .en_t (en_t),
    .carry(carry_out)
  );

  generate
    if (ASYNC_CLR) begin : g_areg
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      cnt_q <= '0;
        else if (upd_en) cnt_q <= cnt_d;
      end
    end else begin : g_sreg
      always_ff @(posedge clk) begin
        if (upd_en) cnt_q <= cnt_d;
      end
    end
  endgenerate

  assign count = cnt_q;

endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic [W-1:0] preset,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] count,
  input logic         carry_out
);

  localparam logic [W-1:0] TERM = W'(term_value(W, DECADE));

  logic [1:0]   warm = 2'd0;
  logic         primed;
  logic [W-1:0] prev_cnt;
  logic [W-1:0] prev_succ;

  always_ff @(posedge clk) begin
    if (warm != 2'd3) warm <= warm + 2'd1;
    prev_cnt <= count;
  end
  assign primed    = (warm == 2'd3);
  assign prev_succ = (prev_cnt == TERM) ? '0 : prev_cnt + W'(1);

  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!primed)
    carry_out == (en_t && count == TERM)); // R6

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !load_n) |=> (!clr_n || count == $past(preset))); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_p && en_t) |=> (!clr_n || count == prev_succ)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && !(en_p && en_t)) |=> (!clr_n || $stable(count))); // R2

  generate
    if (ASYNC_CLR) begin : g_achk
      AST_ASYNC_ZERO: assert property (@(posedge clk) disable iff (!primed)
        !clr_n |-> count == '0); // R5
    end else begin : g_schk
      AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!primed)
        !clr_n |=> count == '0); // R4
    end
  endgenerate

endmodule

bind sync_preset_counter spc_checker #(
  .W        (W),
  .DECADE   (DECADE),
  .ASYNC_CLR(ASYNC_CLR)
) u_chk (.*);

// File: tb/sync_preset_counter_bench.sv
`timescale 1ns/1ps
module sync_preset_counter_bench;

  logic       clk = 1'b0;
  logic       clr_n, load_n, en_p, en_t;
  logic [3:0] preset;
  logic [3:0] cnt_lo, cnt_hi, cnt_dec;
  logic       co_lo, co_hi, co_dec;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  // binary, synchronous clear: low stage
  sync_preset_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_sync_preset_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .en_p(en_p), .en_t(en_t), .count(cnt_lo), .carry_out(co_lo));

  // binary, synchronous clear: high stage driven by low stage carry
  sync_preset_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .en_p(en_p), .en_t(co_lo), .count(cnt_hi), .carry_out(co_hi));

  // decade, asynchronous clear
  sync_preset_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dec (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .en_p(en_p), .en_t(en_t), .count(cnt_dec), .carry_out(co_dec));

  task automatic chk(string req, string what, int actual, int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // advance one edge, land 2 ns after it
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic drive(logic c, logic l, logic [3:0] p, logic ep, logic et);
    clr_n = c; load_n = l; preset = p; en_p = ep; en_t = et;
  endtask

  task automatic t_reset();
    drive(1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
    repeat (4) step();
    chk("R4", "sync clear lo", cnt_lo, 0);
    chk("R4", "sync clear hi", cnt_hi, 0);
    chk("R5", "async clear dec", cnt_dec, 0);
    chk("R6", "carry idle", co_lo, 0);
  endtask

  task automatic t_load_overrides();
    drive(1'b1, 1'b0, 4'd7, 1'b0, 1'b0);
    step();
    chk("R3", "load with enables low lo", cnt_lo, 7);
    chk("R3", "load with enables low dec", cnt_dec, 7);
    drive(1'b1, 1'b0, 4'd12, 1'b1, 1'b1);
    step();
    chk("R3", "load with enables high", cnt_lo, 12);
  endtask

  task automatic t_between_edges();
    drive(1'b1, 1'b1, 4'd3, 1'b0, 1'b0);
    step();
    chk("R2", "hold", cnt_lo, 12);
    load_n = 1'b0; en_p = 1'b1; en_t = 1'b1;
    #1;
    chk("R1", "no change before edge", cnt_lo, 12);
    load_n = 1'b1; en_p = 1'b0;
    #1;
    chk("R1", "still no change", cnt_lo, 12);
    step();
    chk("R2", "en_p low holds", cnt_lo, 12);
    en_p = 1'b1; en_t = 1'b0;
    step();
    chk("R2", "en_t low holds", cnt_lo, 12);
  endtask

  task automatic t_count_and_wrap();
    drive(1'b1, 1'b0, 4'd13, 1'b0, 1'b0);
    step();
    drive(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
    step();
    chk("R2", "count 13->14", cnt_lo, 14);
    chk("R9", "decade 13->14", cnt_dec, 14);
    chk("R9", "decade carry at 14", co_dec, 0);
    step();
    chk("R6", "carry at 15", co_lo, 1);
    chk("R9", "decade 15", cnt_dec, 15);
    chk("R9", "decade carry at 15", co_dec, 0);
    en_t = 1'b0;
    #1;
    chk("R6", "carry gated by en_t", co_lo, 0);
    en_t = 1'b1; en_p = 1'b0;
    #1;
    chk("R6", "en_p has no effect on carry", co_lo, 1);
    en_p = 1'b1;
    step();
    chk("R7", "binary wrap", cnt_lo, 0);
    chk("R9", "decade high code wraps", cnt_dec, 0);
  endtask

  task automatic t_decade_wrap();
    drive(1'b1, 1'b0, 4'd8, 1'b1, 1'b1);
    step();
    load_n = 1'b1;
    step();
    chk("R8", "decade reaches 9", cnt_dec, 9);
    chk("R6", "decade carry at 9", co_dec, 1);
    step();
    chk("R8", "decade 9->0", cnt_dec, 0);
    chk("R6", "decade carry off", co_dec, 0);
  endtask

  task automatic t_sync_clear_priority();
    drive(1'b1, 1'b0, 4'd5, 1'b0, 1'b0);
    step();
    drive(1'b0, 1'b0, 4'd9, 1'b1, 1'b1);
    #1;
    chk("R5", "async clear immediate", cnt_dec, 0);
    chk("R4", "sync clear waits for edge", cnt_lo, 5);
    step();
    chk("R4", "clear beats load", cnt_lo, 0);
    chk("R5", "async clear held", cnt_dec, 0);
  endtask

  task automatic t_cascade();
    drive(1'b1, 1'b0, 4'd14, 1'b1, 1'b1);
    step();
    chk("R10", "cascade load", {cnt_hi, cnt_lo}, 8'hEE);
    load_n = 1'b1;
    step();
    chk("R10", "cascade EF", {cnt_hi, cnt_lo}, 8'hEF);
    step();
    chk("R10", "cascade F0", {cnt_hi, cnt_lo}, 8'hF0);
    step();
    chk("R10", "cascade F1", {cnt_hi, cnt_lo}, 8'hF1);
  endtask

  initial begin
    drive(1'b0, 1'b1, 4'd0, 1'b0, 1'b0);
    t_reset();
    t_load_overrides();
    t_between_edges();
    t_count_and_wrap();
    t_decade_wrap();
    t_sync_clear_priority();
    t_cascade();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule